// File: doc/BRIEF.md
# Serial ADC digital interface slave

This block is the converter-side digital interface of an eight-channel serial analog-to-digital converter. It oversamples chip select, serial clock and serial data in its own system clock domain and collects an 8-bit control byte. It decodes the channel and input configuration from that byte and hands them to the analog front end. It then runs a conversion in one of two clock modes and returns the result MSB-first on the serial data output. The result is taken from a parallel input that carries the straight-binary code of the analog search, and it is re-coded to two's complement when bipolar input is chosen.

In external-clock mode the serial clock sequences the conversion. A one-period strobe marks its start, and the result bits follow on the next falling edges. Chip select going high abandons the conversion and floats both serial outputs. In internal-clock mode a cycle counter times the conversion, and the strobe is low while it runs. The result is held until the host reads it, at any later time and at any serial clock rate. Chip select going high only floats the data output; it does not stop the conversion and does not float the strobe.

Top module: `sar_serial_if`

## Requirements
- R1: While chip select is low, a control byte begins at the first 1 sampled on a rising serial clock edge, and eight bits are taken MSB-first. The byte layout is: bit 7 start, bits 6:4 channel, bit 3 unipolar (1) or bipolar (0), bit 2 single-ended (1) or differential (0), bits 1:0 clock mode. `chan_o` and `single_o` take the byte's fields when a byte with a valid mode completes.
- R2: With mode 2'b11 (external clock), the strobe rises on the falling serial clock edge that follows the last control bit and falls on the next falling edge. It is low at all other times in this mode.
- R3: In external-clock mode, the next RES_W+2 falling edges after the strobe rises present the frame MSB-first: the result code followed by two zero bits. The data output is 0 while the strobe is high and after the last frame bit.
- R4: In external-clock mode, chip select high sets `dout_oe_o` and `strobe_oe_o` low and abandons any conversion or readout in progress. After chip select falls again the strobe is driven low and the data output stays 0.
- R5: With mode 2'b10 (internal clock), the strobe goes low when the control byte completes and returns high exactly CONV_CYC system clock cycles later.
- R6: In internal-clock mode, the result is latched when the conversion ends and held until it is read. The first falling serial clock edge after the strobe rises presents the MSB, and the other frame bits follow as in R3.
- R7: In internal-clock mode, chip select high sets `dout_oe_o` low while `strobe_oe_o` stays high. It does not stop a conversion in progress. Serial clock edges while chip select is high are ignored, and readout resumes after chip select falls.
- R8: With the unipolar bit set, the code is `sample_i` unchanged. With it clear, the MSB of `sample_i` is inverted, which gives two's complement.
- R9: `acq_o` (input acquisition) is high after the fifth bit of a control byte has been taken, and low again once the eighth bit has been taken.
- R10: A control byte with mode 2'b00 or 2'b01 starts nothing. It changes neither the strobe, nor the clock mode, nor `chan_o` or `single_o`.
- R11: Chip select going high in the middle of a control byte discards the partial byte.
- R12: After reset, with chip select high, `dout_o`, `strobe_o`, `dout_oe_o`, `strobe_oe_o`, `acq_o` and `chan_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data in, sampled on rising serial clock edges |
| sample_i | input | RES_W | Straight-binary result of the analog search |
| dout_o | output | 1 | Serial data out, updated on falling serial clock edges |
| dout_oe_o | output | 1 | Output enable for the data output pad |
| strobe_o | output | 1 | Conversion strobe |
| strobe_oe_o | output | 1 | Output enable for the strobe pad |
| acq_o | output | 1 | Input acquisition window |
| chan_o | output | 3 | Selected input channel |
| single_o | output | 1 | Single-ended (1) or differential (0) input |

## Verification
The bench builds the block with RES_W=4 and CONV_CYC=40. With this small result width, every one of the 16 codes can be converted in both polarities and in both clock modes, and each frame bit is compared with a code computed arithmetically. The short conversion count keeps the full sweep within budget. It also lets the bench count the strobe-low time of each internal-mode conversion to the exact cycle, and still raise chip select while a conversion is running.

// File: rtl/sar_serial_if_pkg.sv
package sar_serial_if_pkg;
  localparam int CTRL_W = 8;
  localparam int SUB_W  = 2;
  localparam logic [1:0] MODE_EXT = 2'b11;
  localparam logic [1:0] MODE_INT = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXT_ARM,
    ST_EXT_STB,
    ST_INT_CONV,
    ST_READ
  } st_e;
endpackage

// File: rtl/adc_if_edge.sv
module adc_if_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic din_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_n_o,
  output logic cs_rise_o,
  output logic din_o
);
  logic sclk_q, sclk_qq, cs_q, cs_qq, din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      cs_q    <= 1'b1;
      cs_qq   <= 1'b1;
      din_q   <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      sclk_qq <= sclk_q;
      cs_q    <= cs_ni;
      cs_qq   <= cs_q;
      din_q   <= din_i;
    end
  end

  assign sclk_rise_o = sclk_q & ~sclk_qq;
  assign sclk_fall_o = ~sclk_q & sclk_qq;
  assign cs_n_o      = cs_q;
  assign cs_rise_o   = cs_q & ~cs_qq;
  assign din_o       = din_q;
endmodule

// File: rtl/adc_if_ctrl.sv
module adc_if_ctrl
  import sar_serial_if_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [CTRL_W-2:0] pay_o,
  output logic              acq_o
);
  localparam int PW    = CTRL_W - 1;
  localparam int CNT_W = $clog2(CTRL_W);

  logic [PW-1:0]    pay_q;
  logic [CNT_W-1:0] cnt_q;

  // the start bit only arms the counter; the payload holds the other bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pay_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      if (cnt_q == '0) begin
        if (bit_i) cnt_q <= CNT_W'(1);
      end else begin
        pay_q <= {pay_q[PW-2:0], bit_i};
        cnt_q <= (cnt_q == CNT_W'(CTRL_W-1)) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign done_o = shift_i & ~clear_i & (cnt_q == CNT_W'(CTRL_W-1));
  assign pay_o  = {pay_q[PW-2:0], bit_i};
  assign acq_o  = (cnt_q >= CNT_W'(CTRL_W-3));
endmodule

// File: rtl/adc_if_timer.sv
module adc_if_timer #(
  parameter int CONV_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int TW = $clog2(CONV_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= TW'(CONV_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == TW'(1));
endmodule

// File: rtl/adc_if_oshift.sv
module adc_if_oshift #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         shift_i,
  input  logic         clear_i,
  output logic         dout_o,
  output logic         busy_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      dout_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      dout_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= frame_i;
      cnt_q  <= CW'(W);
      dout_q <= 1'b0;
    end else if (shift_i) begin
      if (cnt_q != '0) begin
        dout_q <= sr_q[W-1];
        sr_q   <= {sr_q[W-2:0], 1'b0};
        cnt_q  <= cnt_q - 1'b1;
      end else begin
        dout_q <= 1'b0;
      end
    end
  end

  assign dout_o = dout_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sar_serial_if.sv
module sar_serial_if
  import sar_serial_if_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int CONV_CYC = 2500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             din_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             strobe_o,
  output logic             strobe_oe_o,
  output logic             acq_o,
  output logic [2:0]       chan_o,
  output logic             single_o
);
  localparam int OUT_W = RES_W + SUB_W;

  logic sclk_rise, sclk_fall, cs_n, cs_rise, din_s;
  logic ctl_done, fall_en, accept, go_ext, go_int;
  logic tmr_done, sh_load, sh_clear, sh_busy;
  logic [CTRL_W-2:0] pay;
  logic [RES_W-1:0]  code;
  logic [OUT_W-1:0]  frame;

  st_e        st_q;
  logic       strobe_q, int_mode_q, uni_q, sgl_q;
  logic [2:0] chan_q;

  adc_if_edge u_edge (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .din_i,
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .cs_n_o(cs_n), .cs_rise_o(cs_rise), .din_o(din_s)
  );

  assign accept  = (st_q == ST_IDLE) || (st_q == ST_READ);
  assign fall_en = sclk_fall & ~cs_n;

  adc_if_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .clear_i(cs_n), .shift_i(sclk_rise & accept), .bit_i(din_s),
    .done_o(ctl_done), .pay_o(pay), .acq_o(acq_o)
  );

  assign go_ext = ctl_done && (pay[1:0] == MODE_EXT);
  assign go_int = ctl_done && (pay[1:0] == MODE_INT);

  adc_if_timer #(.CONV_CYC(CONV_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i(go_int), .done_o(tmr_done)
  );

  // bipolar: offset binary to two's complement by flipping the MSB
  assign code  = uni_q ? sample_i : {~sample_i[RES_W-1], sample_i[RES_W-2:0]};
  assign frame = {code, {SUB_W{1'b0}}};

  assign sh_load  = ((st_q == ST_EXT_ARM) && fall_en) ||
                    ((st_q == ST_INT_CONV) && tmr_done);
  assign sh_clear = cs_rise & ~int_mode_q;

  adc_if_oshift #(.W(OUT_W)) u_osh (
    .clk_i, .rst_ni,
    .load_i(sh_load), .frame_i(frame), .shift_i(fall_en), .clear_i(sh_clear),
    .dout_o(dout_o), .busy_o(sh_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      strobe_q   <= 1'b0;
      int_mode_q <= 1'b0;
      uni_q      <= 1'b0;
      sgl_q      <= 1'b0;
      chan_q     <= '0;
    end else if (go_ext || go_int) begin
      st_q       <= go_ext ? ST_EXT_ARM : ST_INT_CONV;
      int_mode_q <= go_int;
      strobe_q   <= 1'b0;
      chan_q     <= pay[6:4];
      uni_q      <= pay[3];
      sgl_q      <= pay[2];
    end else begin
      unique case (st_q)
        ST_EXT_ARM: begin
          if (cs_rise) st_q <= ST_IDLE;
          else if (fall_en) begin
            st_q     <= ST_EXT_STB;
            strobe_q <= 1'b1;
          end
        end
        ST_EXT_STB: begin
          if (cs_rise) begin
            st_q     <= ST_IDLE;
            strobe_q <= 1'b0;
          end else if (fall_en) begin
            st_q     <= ST_READ;
            strobe_q <= 1'b0;
          end
        end
        ST_INT_CONV: begin
          if (tmr_done) begin
            st_q     <= ST_READ;
            strobe_q <= 1'b1;
          end
        end
        ST_READ: begin
          if ((!int_mode_q && cs_rise) || !sh_busy) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign strobe_o    = strobe_q;
  assign dout_oe_o   = ~cs_n;
  assign strobe_oe_o = int_mode_q | ~cs_n;
  assign chan_o      = chan_q;
  assign single_o    = sgl_q;
endmodule

// File: rtl/sar_serial_if_chk.sv
module sar_serial_if_chk
  import sar_serial_if_pkg::*;
#(
  parameter int CONV_CYC = 2500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic strobe_o,
  input logic strobe_oe_o,
  input logic dout_oe_o,
  input logic acq_o,
  input st_e  st,
  input logic int_mode
);
  int conv_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                conv_cnt <= 0;
    else if (st == ST_INT_CONV) conv_cnt <= conv_cnt + 1;
    else                        conv_cnt <= 0;
  end

  // R2: in external mode the strobe is high only in its one-period slot
  a_r2_strobe_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_mode && st != ST_EXT_STB) |-> !strobe_o);

  // R4: chip select high floats the data pad, and the strobe pad in external mode
  a_r4_cs_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> (!dout_oe_o && (int_mode || !strobe_oe_o)));

  // R5: an internal conversion never outlasts its count
  a_r5_conv_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_INT_CONV) |-> (conv_cnt < CONV_CYC));

  // R5: and it ends exactly when the count is reached
  a_r5_conv_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_INT_CONV && conv_cnt == CONV_CYC - 1) |=> (st != ST_INT_CONV));

  // R7: chip select high does not abort an internal conversion
  a_r7_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_ni) && st == ST_INT_CONV) |=> (st != ST_IDLE));

  // R9: acquisition only while a control byte is being accepted
  a_r9_acq_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_o |-> (st == ST_IDLE || st == ST_READ));
endmodule

bind sar_serial_if sar_serial_if_chk #(.CONV_CYC(CONV_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
  .strobe_o(strobe_o), .strobe_oe_o(strobe_oe_o), .dout_oe_o(dout_oe_o),
  .acq_o(acq_o), .st(st_q), .int_mode(int_mode_q)
);

// File: tb/sim_sar_serial_if.sv
module sim_sar_serial_if;
  localparam int RES_W    = 4;
  localparam int CONV_CYC = 40;
  localparam int OUT_W    = RES_W + 2;
  localparam int H        = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [RES_W-1:0] sample = '0;
  logic dout_o, dout_oe_o, strobe_o, strobe_oe_o, acq_o, single_o;
  logic [2:0] chan_o;

  int n_chk = 0, n_fail = 0;
  int low_run = 0, last_run = 0;
  bit reported = 0;
  string ctx = "";

  always #2 clk = ~clk;

  sar_serial_if #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .sample_i(sample), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .strobe_o(strobe_o), .strobe_oe_o(strobe_oe_o), .acq_o(acq_o),
    .chan_o(chan_o), .single_o(single_o)
  );

  always @(negedge clk) begin
    if (strobe_o === 1'b0) low_run++;
    else begin
      if (low_run != 0) last_run = low_run;
      low_run = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, ctx, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", ctx, 1, 0);
    report();
  end

  function automatic logic [OUT_W-1:0] exp_frame(input int code, input bit uni);
    logic [RES_W-1:0] c;
    c = RES_W'(code);
    if (!uni) c[RES_W-1] = ~c[RES_W-1];
    return {c, 2'b00};
  endfunction

  function automatic logic [7:0] mk_ctrl(input int chan, input bit uni, input bit sgl,
                                         input logic [1:0] md);
    return {1'b1, 3'(chan), uni, sgl, md};
  endfunction

  task automatic bit_clk(input logic b);
    din = b;
    @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_set(input logic v);
    cs_n = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_ctrl(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) begin
      bit_clk(c[i]);
      check("R9", int'(acq_o), int'((8 - i) >= 5 && (8 - i) <= 7));
    end
  endtask

  task automatic read_frame(input logic [OUT_W-1:0] f, input bit ext);
    for (int i = OUT_W - 1; i >= 0; i--) begin
      bit_clk(1'b0);
      if (ext && i == OUT_W - 1) check("R2", int'(strobe_o), 0);
      check(ext ? "R3/R8" : "R6/R8", int'(dout_o), int'(f[i]));
    end
    bit_clk(1'b0);
    check(ext ? "R3" : "R6", int'(dout_o), 0);
  endtask

  task automatic ext_conv(input int code, input bit uni);
    bit sgl;
    sgl = bit'(code & 1) ^ uni;
    sample = RES_W'(code);
    cs_set(1'b0);
    send_ctrl(mk_ctrl(code % 8, uni, sgl, 2'b11));
    check("R1", int'(chan_o), code % 8);
    check("R1", int'(single_o), int'(sgl));
    check("R2", int'(strobe_o), 1);
    check("R3", int'(dout_o), 0);
    check("R4", int'(strobe_oe_o), 1);
    read_frame(exp_frame(code, uni), 1'b1);
    cs_set(1'b1);
    check("R4", int'(dout_oe_o), 0);
    check("R4", int'(strobe_oe_o), 0);
  endtask

  task automatic int_conv(input int code, input bit uni);
    bit was_hi;
    int t;
    was_hi = (strobe_o === 1'b1);
    sample = RES_W'(code);
    cs_set(1'b0);
    send_ctrl(mk_ctrl(code % 8, uni, 1'b1, 2'b10));
    check("R1", int'(chan_o), code % 8);
    check("R5", int'(strobe_o), 0);
    check("R7", int'(strobe_oe_o), 1);
    t = 0;
    while (strobe_o !== 1'b1 && t < 4 * CONV_CYC) begin
      @(negedge clk);
      t++;
    end
    check("R5", int'(strobe_o), 1);
    @(negedge clk);
    if (was_hi) check("R5", last_run, CONV_CYC);
    repeat (100) @(negedge clk);
    read_frame(exp_frame(code, uni), 1'b0);
    cs_set(1'b1);
    check("R7", int'(dout_oe_o), 0);
    check("R7", int'(strobe_oe_o), 1);
    check("R6", int'(strobe_o), 1);
  endtask

  initial begin
    ctx = "reset";
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", int'(dout_o), 0);
    check("R12", int'(strobe_o), 0);
    check("R12", int'(dout_oe_o), 0);
    check("R12", int'(strobe_oe_o), 0);
    check("R12", int'(acq_o), 0);
    check("R12", int'(chan_o), 0);

    ctx = "external sweep";
    for (int code = 0; code < (1 << RES_W); code++)
      for (int u = 0; u < 2; u++) ext_conv(code, bit'(u));

    ctx = "R4 abort";
    sample = RES_W'(6);
    cs_set(1'b0);
    send_ctrl(mk_ctrl(6, 1'b1, 1'b0, 2'b11));
    for (int i = 0; i < 3; i++) bit_clk(1'b0);
    cs_set(1'b1);
    check("R4", int'(dout_oe_o), 0);
    check("R4", int'(strobe_oe_o), 0);
    cs_set(1'b0);
    check("R4", int'(strobe_oe_o), 1);
    check("R4", int'(strobe_o), 0);
    for (int i = 0; i < 3; i++) begin
      bit_clk(1'b0);
      check("R4", int'(dout_o), 0);
    end
    cs_set(1'b1);

    ctx = "R11 partial byte";
    cs_set(1'b0);
    for (int i = 0; i < 4; i++) bit_clk(1'b1);
    cs_set(1'b1);
    ext_conv(3, 1'b1);

    ctx = "internal sweep";
    for (int code = 0; code < (1 << RES_W); code++)
      for (int u = 0; u < 2; u++) int_conv(code, bit'(u));

    ctx = "R7 cs high during conversion";
    sample = RES_W'(9);
    cs_set(1'b0);
    send_ctrl(mk_ctrl(1, 1'b0, 1'b0, 2'b10));
    cs_set(1'b1);
    check("R7", int'(dout_oe_o), 0);
    check("R7", int'(strobe_oe_o), 1);
    check("R7", int'(strobe_o), 0);
    for (int i = 0; i < 3; i++) bit_clk(1'b0);
    for (int t = 0; t < 4 * CONV_CYC && strobe_o !== 1'b1; t++) @(negedge clk);
    check("R7", int'(strobe_o), 1);
    cs_set(1'b0);
    read_frame(exp_frame(9, 1'b0), 1'b0);
    cs_set(1'b1);

    ctx = "R10 idle modes";
    for (int m = 0; m < 2; m++) begin
      cs_set(1'b0);
      send_ctrl(mk_ctrl(5, 1'b1, 1'b1, 2'(m)));
      check("R10", int'(strobe_o), 1);
      check("R10", int'(chan_o), 1);
      check("R10", int'(single_o), 0);
      bit_clk(1'b0);
      check("R10", int'(dout_o), 0);
      cs_set(1'b1);
      check("R10", int'(strobe_oe_o), 1);
    end

    report();
  end
endmodule